// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block lets a processor reach external PHY management registers over a two-wire MDIO bus. Software sets the framing mode, the PHY and register (or device) address, and a 16-bit data word through a small register port. It then writes a start command and polls a busy flag until the bus transaction completes. The block supports both Clause 22 and Clause 45 framing. In Clause 45 mode, software issues the address cycle and the data cycle as two separate commands. Both cycles take their 16-bit payload from the same write-data register, which software reloads between them.

The block derives the MDC clock from its system clock through an even divider. It shifts out a 64-bit frame most significant bit first: a preamble, the start and opcode fields, two 5-bit address fields, a turnaround and 16 data bits. On read frames it releases the MDIO line for the turnaround and data bits. It samples the returned bits on rising MDC edges and places the captured word in a read-data register.

The register port has no wait states. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the current address. MDIO is presented as a separate output, output enable and input; the pad and pull-up sit outside the block. The divider parameter must be even and at least 4.

Top module: `mdio_master`

## Requirements
- R1: Registers reset to 0. Offset 0x40 holds the framing select in bit 8 (0 = Clause 22, 1 = Clause 45), and its other bits read 0. Offset 0x44 holds the PHY address in bits 12:8 and the register or device number in bits 4:0. Offset 0x48 holds a 16-bit write-data word. Offset 0x4C returns the read data. Any other offset reads 0.
- R2: A write to offset 0x50 with bit 8 set, made while idle, starts a frame. Bit 16 of offset 0x50 reads 1 from the next cycle until the frame ends. A command write with bit 8 clear starts nothing.
- R3: Every frame is 64 MDC periods, sent most significant bit first, in this order: 32 ones, 2 start bits, 2 opcode bits, the 5-bit PHY address, the 5-bit register or device number, 2 turnaround bits and 16 data bits.
- R4: In Clause 22 mode the start bits are 01. A command code (bits 1:0 of the command) whose bit 0 is 0 sends a read with opcode 10. A code whose bit 0 is 1 sends a write with opcode 01 carrying the write-data word.
- R5: In Clause 45 mode the start bits are 00. Code 0 sends an address cycle with opcode 00, code 1 sends a write with opcode 01, and codes 2 and 3 send a read with opcode 11. Address and write cycles both carry the write-data word as their 16 data bits.
- R6: One MDC period equals CLK_DIV system clocks: a low half followed by a high half. MDC rests low between frames. MDIO changes only while MDC is low.
- R7: On write and address frames, the master drives MDIO for all 64 bits, and the turnaround field is 10.
- R8: On read frames, the master drives the first 46 bits and releases MDIO from the first turnaround bit to the end of the frame. It samples the 16 data bits on the rising MDC edges.
- R9: When a read frame ends, its 16 sampled bits appear at offset 0x4C. Write and address frames leave that value unchanged.
- R10: A start command issued while busy is ignored. No second frame follows, and register writes made during a frame do not alter the frame already in flight.
- R11: The MDIO output enable is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busWrData | input | 16 | Register write data |
| busRdData | output | 32 | Register read data for busAddr |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | MDIO value driven when mdioOe is high |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO line as seen at the pad |

## Verification
The bench builds the block with CLK_DIV set to 4, which makes a full frame 256 system clocks. At that length the run can cover every opcode in both framings, a command overlapping a running frame, and repeated reads of the busy flag, all well inside the cycle budget. A divisor of 4 also puts the rising-edge sample and the frame-end strobe one cycle apart, which is the tightest spacing the design allows. That case checks that the last data bit is captured before the read-data register updates.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;  // index of first turnaround bit in a frame
  localparam int DATA_POS  = 48;  // index of first data bit in a frame

  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;     // latch a new frame
    logic fall;     // MDC falling edge, present next bit
    logic rise;     // MDC rising edge
    logic letGo;    // first turnaround bit: reads release the line
    logic capture;  // rising edge within the data field
    logic finish;   // last cycle of the frame
  } dp_ctl_t;

  function automatic logic [1:0] opFor(input logic c45, input logic [1:0] code);
    if (!c45) return code[0] ? 2'b01 : 2'b10;
    case (code)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic isReadOp(input logic c45, input logic [1:0] code);
    return c45 ? code[1] : !code[0];
  endfunction

  function automatic logic [FRAME_LEN-1:0] buildFrame(
      input logic c45, input logic [1:0] code, input logic [4:0] phyAd,
      input logic [4:0] regAd, input logic [15:0] data);
    return {{PRE_LEN{1'b1}}, (c45 ? 2'b00 : 2'b01), opFor(c45, code),
            phyAd, regAd, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [15:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [15:0] rdData,
  output dp_ctl_t     ctl,
  output logic        c45,
  output logic [1:0]  code,
  output logic [4:0]  phyAd,
  output logic [4:0]  regAd,
  output logic [15:0] wrData
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(FRAME_LEN);

  logic             busyQ;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             startReq, startOk, lastDiv, lastBit;

  assign startReq = busWrEn && (busAddr == OFS_CMD) && busWrData[8];
  assign startOk  = startReq && !busyQ;
  assign lastDiv  = divCnt == DIV_W'(CLK_DIV - 1);
  assign lastBit  = bitCnt == BIT_W'(FRAME_LEN - 1);
  assign code     = busWrData[1:0];

  always_comb begin
    ctl.load    = startOk;
    ctl.fall    = busyQ && (divCnt == '0);
    ctl.rise    = busyQ && (divCnt == DIV_W'(HALF));
    ctl.letGo   = ctl.fall && (bitCnt == BIT_W'(TA_POS));
    ctl.capture = ctl.rise && (bitCnt >= BIT_W'(DATA_POS));
    ctl.finish  = busyQ && lastDiv && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c45    <= 1'b0;
      phyAd  <= '0;
      regAd  <= '0;
      wrData <= '0;
    end else if (busWrEn) begin
      if (busAddr == OFS_MODE)  c45 <= busWrData[8];
      if (busAddr == OFS_ADDR)  begin phyAd <= busWrData[12:8]; regAd <= busWrData[4:0]; end
      if (busAddr == OFS_WDATA) wrData <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (startOk) begin
      busyQ  <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busyQ) begin
      if (lastDiv) begin
        divCnt <= '0;
        bitCnt <= bitCnt + 1'b1;
        if (lastBit) busyQ <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (busAddr)
      OFS_MODE:  busRdData = {23'b0, c45, 8'b0};
      OFS_ADDR:  busRdData = {19'b0, phyAd, 3'b0, regAd};
      OFS_WDATA: busRdData = {16'b0, wrData};
      OFS_RDATA: busRdData = {16'b0, rdData};
      OFS_CMD:   busRdData = {15'b0, busyQ, 16'b0};
      default:   busRdData = '0;
    endcase
  end

  // R2: an accepted start makes the block busy on the next cycle
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> busyQ);
  // R10: busy is held until the frame's final cycle
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !ctl.finish |=> busyQ);
  // R10: no new frame is loaded while one runs
  a_r10_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !ctl.load);
  // R6: edge strobes never coincide
  a_r6_strobes_apart: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.fall, ctl.rise, ctl.finish}));
endmodule

// File: rtl/mdio_datapath.sv
`timescale 1ns/1ps
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dp_ctl_t     ctl,
  input  logic        c45,
  input  logic [1:0]  code,
  input  logic [4:0]  phyAd,
  input  logic [4:0]  regAd,
  input  logic [15:0] wrData,
  input  logic        mdioIn,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [15:0] rdData
);
  logic [FRAME_LEN-1:0] shiftQ;
  logic                 readQ;
  logic [15:0]          rxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      readQ   <= 1'b0;
      rxQ     <= '0;
      rdData  <= '0;
      mdc     <= 1'b0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      if (ctl.load) begin
        shiftQ  <= buildFrame(c45, code, phyAd, regAd, wrData);
        readQ   <= isReadOp(c45, code);
        mdioOut <= 1'b1;
        mdioOe  <= 1'b1;
      end
      if (ctl.fall) begin
        mdc     <= 1'b0;
        mdioOut <= shiftQ[FRAME_LEN-1];
        shiftQ  <= {shiftQ[FRAME_LEN-2:0], 1'b0};
        if (ctl.letGo && readQ) mdioOe <= 1'b0;
      end
      if (ctl.rise) begin
        mdc <= 1'b1;
        if (ctl.capture && readQ) rxQ <= {rxQ[14:0], mdioIn};
      end
      if (ctl.finish) begin
        mdc    <= 1'b0;
        mdioOe <= 1'b0;
        if (readQ) rdData <= rxQ;
      end
    end
  end

  // R8: the line is released only at a read's turnaround or at frame end
  a_r8_release_point: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdioOe) |-> $past(ctl.finish || (ctl.letGo && readQ)));
  // R6: MDIO holds steady through the high half of MDC
  a_r6_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    mdc && $past(mdc) |-> $stable(mdioOut));
  // R11: after a frame the line and clock rest
  a_r11_rest_after: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> !mdc && !mdioOe);
  // R9: read data only moves at the end of a read frame
  a_r9_rdata_update: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(ctl.finish && readQ));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [15:0] busWrData,
  output logic [31:0] busRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dp_ctl_t     ctl;
  logic        c45;
  logic [1:0]  code;
  logic [4:0]  phyAd, regAd;
  logic [15:0] wrData, rdData;

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .rdData(rdData),
    .ctl(ctl), .c45(c45), .code(code), .phyAd(phyAd), .regAd(regAd),
    .wrData(wrData));

  mdio_datapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .c45(c45), .code(code),
    .phyAd(phyAd), .regAd(regAd), .wrData(wrData), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData));
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe, mdioLine;

  always #2.5 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioLine));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // scoreboard queues filled by the driver
  logic [63:0] expFrameQ[$];
  logic [63:0] expOeQ[$];
  string       tagQ[$];

  // PHY model state
  logic [15:0] phyVal = '0;
  int          cnt = 0;
  logic [63:0] capF, capO;
  logic        prevMdc = 1'b0, prevOut = 1'b0;
  int          cycle = 0, riseAt0 = 0;
  bit          edgeViolation = 0;

  // pull-up when nobody drives; PHY drives 0 on second turnaround bit, then data
  assign mdioLine = mdioOe ? mdioOut :
                    (cnt == 47) ? 1'b0 :
                    (cnt >= 48 && cnt <= 63) ? phyVal[63 - cnt] : 1'b1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: collects each frame bit at MDC rising edges and compares
  always @(negedge clk) begin
    cycle++;
    if (rstN && mdc && prevMdc && (mdioOut != prevOut)) edgeViolation = 1;
    if (rstN && mdc && !prevMdc) begin
      capF[63 - cnt] = mdioLine;
      capO[63 - cnt] = mdioOe;
      if (cnt == 0) riseAt0 = cycle;
      if (cnt == 1) check((cycle - riseAt0) == DIV, "R6 mdc period", 64'(cycle - riseAt0), 64'(DIV));
      if (cnt == 63) begin
        if (expFrameQ.size() == 0) begin
          check(0, "R10 unexpected frame", capF, 64'h0);
        end else begin
          logic [63:0] ef, eo;
          string t;
          ef = expFrameQ.pop_front();
          eo = expOeQ.pop_front();
          t  = tagQ.pop_front();
          check(capF == ef, {t, " R3 frame bits"}, capF, ef);
          check(capO == eo, {t, " output enable per bit"}, capO, eo);
        end
        cnt = 0;
      end else begin
        cnt++;
      end
    end
    prevMdc = mdc;
    prevOut = mdioOut;
  end

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    int n = 0;
    do begin
      busRead(8'h50, v);
      n++;
    end while (v[16] && n < 5000);
  endtask

  task automatic runOp(input bit c45, input logic [1:0] code, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd, input logic [15:0] pv,
                       input string tag, input bit interfere);
    logic [31:0] v;
    logic [1:0]  st, op;
    bit          rd;
    busWrite(8'h40, {7'b0, c45, 8'b0});
    busWrite(8'h44, {3'b0, phy, 3'b0, rg});
    busWrite(8'h48, wd);
    phyVal = pv;
    rd = c45 ? code[1] : !code[0];
    st = c45 ? 2'b00 : 2'b01;
    if (c45) op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
    else     op = code[0] ? 2'b01 : 2'b10;
    expFrameQ.push_back({32'hFFFF_FFFF, st, op, phy, rg, 2'b10, (rd ? pv : wd)});
    expOeQ.push_back(rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}});
    tagQ.push_back(tag);
    busWrite(8'h50, {8'h01, 6'b0, code});
    busRead(8'h50, v);
    check(v[16] == 1'b1, "R2 busy after start", 64'(v), 64'h10000);
    if (interfere) begin
      repeat (60) @(negedge clk);
      busWrite(8'h50, 16'h0100);   // start while busy
      busWrite(8'h48, 16'hFFFF);   // rewrite data mid-frame
    end
    waitIdle();
    if (rd) begin
      busRead(8'h4C, v);
      check(v == {16'b0, pv}, {tag, " R9 read data"}, 64'(v), 64'(pv));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    // reset state
    check(mdc == 1'b0, "R6 mdc low in reset", 64'(mdc), 0);
    check(mdioOe == 1'b0, "R11 oe low in reset", 64'(mdioOe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    foreach (v[i]) v[i] = 1'b0;
    busRead(8'h40, v); check(v == 0, "R1 mode reset", 64'(v), 0);
    busRead(8'h44, v); check(v == 0, "R1 addr reset", 64'(v), 0);
    busRead(8'h48, v); check(v == 0, "R1 wdata reset", 64'(v), 0);
    busRead(8'h4C, v); check(v == 0, "R1 rdata reset", 64'(v), 0);
    busRead(8'h50, v); check(v == 0, "R2 idle after reset", 64'(v), 0);

    // register readback
    busWrite(8'h40, 16'hFFFF); busRead(8'h40, v);
    check(v == 32'h100, "R1 mode only bit 8", 64'(v), 64'h100);
    busWrite(8'h44, 16'hFFFF); busRead(8'h44, v);
    check(v == 32'h1F1F, "R1 addr fields", 64'(v), 64'h1F1F);
    busWrite(8'h48, 16'hA5C3); busRead(8'h48, v);
    check(v == 32'hA5C3, "R1 wdata", 64'(v), 64'hA5C3);
    busRead(8'h54, v);
    check(v == 0, "R1 unmapped reads 0", 64'(v), 0);

    // command without start bit
    busWrite(8'h50, 16'h0001);
    repeat (3 * DIV) @(negedge clk);
    busRead(8'h50, v);
    check(v[16] == 1'b0 && cnt == 0, "R2 no start without bit 8", 64'(v), 0);

    runOp(1'b0, 2'd1, 5'h11, 5'h0A, 16'hBEEF, 16'h0000, "R4 R7 c22 write", 1'b0);
    runOp(1'b0, 2'd0, 5'h03, 5'h1F, 16'h0000, 16'h1234, "R4 R8 c22 read", 1'b0);
    runOp(1'b0, 2'd1, 5'h01, 5'h00, 16'h7777, 16'h0000, "R4 c22 write", 1'b0);
    busRead(8'h4C, v);
    check(v == 32'h1234, "R9 read data kept after write", 64'(v), 64'h1234);
    runOp(1'b1, 2'd0, 5'h1E, 5'h07, 16'h8001, 16'h0000, "R5 R7 c45 address", 1'b0);
    runOp(1'b1, 2'd1, 5'h1E, 5'h07, 16'h5A5A, 16'h0000, "R5 c45 write", 1'b0);
    runOp(1'b1, 2'd2, 5'h1E, 5'h07, 16'h0000, 16'hC0DE, "R5 R8 c45 read", 1'b0);
    busRead(8'h4C, v);
    check(v == 32'hC0DE, "R9 c45 read data", 64'(v), 64'hC0DE);

    // idle rest state
    repeat (2) @(negedge clk);
    check(mdc == 1'b0, "R6 mdc low when idle", 64'(mdc), 0);
    check(mdioOe == 1'b0, "R11 oe low when idle", 64'(mdioOe), 0);

    // start and data rewrite during a frame
    runOp(1'b0, 2'd1, 5'h01, 5'h02, 16'h0F0F, 16'h0000, "R10 frame in flight", 1'b1);
    repeat (3 * 64 * DIV) @(negedge clk);
    busRead(8'h50, v);
    check(v[16] == 1'b0 && cnt == 0 && expFrameQ.size() == 0,
          "R10 start while busy ignored", 64'(cnt), 0);

    check(!edgeViolation, "R6 mdio changes only while mdc low", 64'(edgeViolation), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule